// File: doc/BRIEF.md
# Power-Management Event Block with Level Interrupt

This block holds the fixed power-management event registers of a platform controller: a 16-bit event status register, a 16-bit event enable register two bytes above it, and a general-purpose event (GPE) status/enable byte pair. It gathers every status/enable pair into a single level-sensitive system control interrupt output, `sci`. Software reaches the registers over a simple one-request-per-cycle I/O bus that carries an access width in bytes. Each register accepts only its own access width.

Two hardware event inputs can set status bits. A power-button pulse sets the power-button status flag. A GPE raise request names one GPE line by index. Status flags are cleared by writing ones, but only in the positions that allow it. Enable writes keep only the positions the block implements. The interrupt level is recomputed from the register contents after every write and every event.

The timer, RTC and bus-master event sources are not part of this block. Their status positions exist only as clearable or read-as-zero bits.

Top module: `pm_event_sci`

## Requirements
- R1: After synchronous reset all four registers read 0, `sci` is low, and `io_ack`, `io_err` and `io_rdata` are 0.
- R2: Register offsets are 0x0 for event status, 0x2 for event enable, 0x4 for GPE status and 0x5 for GPE enable. Event status positions are timer 0, bus master 4, global 5, power button 8, sleep button 9, RTC 10 and wake 15. A status write clears a set bit wherever it writes a 1 in positions 4, 8, 9, 10 or 15. In positions 0 and 5 it has no effect, and a status write never sets any bit.
- R3: A write to event enable keeps only positions 5 (global), 8 (power button) and 10 (RTC). Every other enable bit reads 0.
- R4: Event status and event enable accept only `io_bytes`=2, and the GPE registers accept only `io_bytes`=1. A wrong width is answered with `io_err`=1 and read data 0, and it changes no register.
- R5: A one-cycle `pwrbtn_evt` sets status bit 8. If it coincides with a write that clears bit 8, the bit stays set.
- R6: GPE status is write-one-to-clear, limited to the positions set in `GPE_VALID`. A raise on index i sets bit i only when `GPE_VALID[i]` is 1, and a raise wins over a clear of the same bit in the same cycle.
- R7: A write to GPE enable stores `wdata & GPE_VALID`.
- R8: `sci` is high exactly when, one cycle earlier, an event status bit was set together with its enable bit (positions 0, 5, 8, 9, 10), or a GPE status bit was set together with its GPE enable bit.
- R9: Every request cycle is answered one cycle later with `io_ack`=1. On an accepted read, `io_rdata` carries the register (GPE registers zero-extended); otherwise `io_rdata` is 0.
- R10: An address other than the four register offsets is answered with `io_err`=1 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Request strobe, one cycle per access |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | ADDR_W | Register offset |
| io_bytes | input | 3 | Access width in bytes |
| io_wdata | input | 16 | Write data |
| io_ack | output | 1 | Response strobe, one cycle after the request |
| io_err | output | 1 | Request rejected (width or address) |
| io_rdata | output | 16 | Read data, valid with `io_ack` |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| gpe_raise | input | 1 | GPE raise request |
| gpe_raise_idx | input | IDX_W | Index of the GPE line to raise |
| sci | output | 1 | Level system control interrupt |

## Verification
The bench builds the block with `GPE_W`=8 and `GPE_VALID`=0x05, so two GPE lines are valid. This exposes both a valid line outside bit 0 and an invalid line between the two valid ones. With that setting the bench can show a raise on the invalid index being dropped, an enable write of 0xFF being trimmed to 0x05, and an interrupt that comes from GPE line 2 alone. It also shows an enabled status bit held high while its enable is removed, which drops `sci`.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int DATA_W = 16;

  // register offsets on the I/O bus
  localparam int OFS_PM1_STS = 'h0;
  localparam int OFS_PM1_EN  = 'h2;
  localparam int OFS_GPE_STS = 'h4;
  localparam int OFS_GPE_EN  = 'h5;

  // access widths in bytes
  localparam logic [2:0] PM1_BYTES = 3'd2;
  localparam logic [2:0] GPE_BYTES = 3'd1;

  // event status / enable bit positions
  localparam int BIT_TMR    = 0;
  localparam int BIT_BUSM   = 4;
  localparam int BIT_GLOBAL = 5;
  localparam int BIT_PWRBTN = 8;
  localparam int BIT_SLPBTN = 9;
  localparam int BIT_RTC    = 10;
  localparam int BIT_WAKE   = 15;

  localparam logic [DATA_W-1:0] PM1_W1C_MASK =
    (16'h1 << BIT_WAKE) | (16'h1 << BIT_RTC) | (16'h1 << BIT_SLPBTN) |
    (16'h1 << BIT_PWRBTN) | (16'h1 << BIT_BUSM);
  localparam logic [DATA_W-1:0] PM1_EN_KEEP =
    (16'h1 << BIT_RTC) | (16'h1 << BIT_PWRBTN) | (16'h1 << BIT_GLOBAL);
  localparam logic [DATA_W-1:0] PM1_IRQ_PAIRS =
    (16'h1 << BIT_TMR) | (16'h1 << BIT_GLOBAL) | (16'h1 << BIT_PWRBTN) |
    (16'h1 << BIT_SLPBTN) | (16'h1 << BIT_RTC);

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PM1_STS,
    SEL_PM1_EN,
    SEL_GPE_STS,
    SEL_GPE_EN
  } reg_sel_e;
endpackage

// File: rtl/pm_evt_decode.sv
module pm_evt_decode
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_bytes,
  output reg_sel_e          sel,
  output logic              accept,
  output logic              reject
);
  logic size_ok;

  always_comb begin
    sel     = SEL_NONE;
    size_ok = 1'b0;
    if (req_addr == ADDR_W'(OFS_PM1_STS)) begin
      sel = SEL_PM1_STS; size_ok = (req_bytes == PM1_BYTES);
    end else if (req_addr == ADDR_W'(OFS_PM1_EN)) begin
      sel = SEL_PM1_EN;  size_ok = (req_bytes == PM1_BYTES);
    end else if (req_addr == ADDR_W'(OFS_GPE_STS)) begin
      sel = SEL_GPE_STS; size_ok = (req_bytes == GPE_BYTES);
    end else if (req_addr == ADDR_W'(OFS_GPE_EN)) begin
      sel = SEL_GPE_EN;  size_ok = (req_bytes == GPE_BYTES);
    end
  end

  assign accept = req_valid && (sel != SEL_NONE) && size_ok;
  assign reject = req_valid && !accept;
endmodule

// File: rtl/pm1_evt_regs.sv
module pm1_evt_regs
  import pm_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sts_we,
  input  logic              en_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pwrbtn_set,
  output logic [DATA_W-1:0] sts_q,
  output logic [DATA_W-1:0] en_q
);
  logic [DATA_W-1:0] clr_bits;
  logic [DATA_W-1:0] sts_d;

  always_comb begin
    clr_bits = sts_we ? (wdata & PM1_W1C_MASK) : '0;
    sts_d    = sts_q & ~clr_bits;
    // an event in the same cycle as a clear keeps the flag
    if (pwrbtn_set) sts_d[BIT_PWRBTN] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      if (en_we) en_q <= wdata & PM1_EN_KEEP;
    end
  end
endmodule

// File: rtl/gpe_evt_regs.sv
module gpe_evt_regs #(
  parameter int               GPE_W     = 8,
  parameter logic [GPE_W-1:0] GPE_VALID = 'h01,
  parameter int               IDX_W     = (GPE_W > 1) ? $clog2(GPE_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sts_we,
  input  logic             en_we,
  input  logic [GPE_W-1:0] wdata,
  input  logic             raise,
  input  logic [IDX_W-1:0] raise_idx,
  output logic [GPE_W-1:0] sts_q,
  output logic [GPE_W-1:0] en_q
);
  logic [GPE_W-1:0] raise_hot;
  logic [GPE_W-1:0] clr_bits;

  for (genvar i = 0; i < GPE_W; i++) begin : g_hot
    assign raise_hot[i] = raise && (raise_idx == IDX_W'(i));
  end

  assign clr_bits = sts_we ? (wdata & GPE_VALID) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      // set has priority over a clear of the same bit
      sts_q <= ((sts_q & ~clr_bits) | raise_hot) & GPE_VALID;
      if (en_we) en_q <= wdata & GPE_VALID;
    end
  end
endmodule

// File: rtl/sci_level_gen.sv
module sci_level_gen
  import pm_evt_pkg::*;
#(
  parameter int GPE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pm1_sts,
  input  logic [DATA_W-1:0] pm1_en,
  input  logic [GPE_W-1:0]  gpe_sts,
  input  logic [GPE_W-1:0]  gpe_en,
  output logic              sci
);
  logic pm1_hit, gpe_hit;

  assign pm1_hit = |(pm1_sts & pm1_en & PM1_IRQ_PAIRS);
  assign gpe_hit = |(gpe_sts & gpe_en);

  always_ff @(posedge clk) begin
    if (rst) sci <= 1'b0;
    else     sci <= pm1_hit || gpe_hit;
  end
endmodule

// File: rtl/pm_event_sci.sv
module pm_event_sci
  import pm_evt_pkg::*;
#(
  parameter int               ADDR_W    = 4,
  parameter int               GPE_W     = 8,
  parameter logic [GPE_W-1:0] GPE_VALID = 'h01,
  parameter int               IDX_W     = (GPE_W > 1) ? $clog2(GPE_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [2:0]        io_bytes,
  input  logic [15:0]       io_wdata,
  output logic              io_ack,
  output logic              io_err,
  output logic [15:0]       io_rdata,
  input  logic              pwrbtn_evt,
  input  logic              gpe_raise,
  input  logic [IDX_W-1:0]  gpe_raise_idx,
  output logic              sci
);
  reg_sel_e          sel;
  logic              accept, reject;
  logic [DATA_W-1:0] pm1_sts_q, pm1_en_q;
  logic [GPE_W-1:0]  gpe_sts_q, gpe_en_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_ok, rd_ok;

  assign wr_ok = accept && io_write;
  assign rd_ok = accept && !io_write;

  pm_evt_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (io_valid),
    .req_addr  (io_addr),
    .req_bytes (io_bytes),
    .sel       (sel),
    .accept    (accept),
    .reject    (reject)
  );

  pm1_evt_regs u_pm1 (
    .clk        (clk),
    .rst        (rst),
    .sts_we     (wr_ok && sel == SEL_PM1_STS),
    .en_we      (wr_ok && sel == SEL_PM1_EN),
    .wdata      (io_wdata),
    .pwrbtn_set (pwrbtn_evt),
    .sts_q      (pm1_sts_q),
    .en_q       (pm1_en_q)
  );

  gpe_evt_regs #(.GPE_W(GPE_W), .GPE_VALID(GPE_VALID), .IDX_W(IDX_W)) u_gpe (
    .clk       (clk),
    .rst       (rst),
    .sts_we    (wr_ok && sel == SEL_GPE_STS),
    .en_we     (wr_ok && sel == SEL_GPE_EN),
    .wdata     (io_wdata[GPE_W-1:0]),
    .raise     (gpe_raise),
    .raise_idx (gpe_raise_idx),
    .sts_q     (gpe_sts_q),
    .en_q      (gpe_en_q)
  );

  sci_level_gen #(.GPE_W(GPE_W)) u_sci (
    .clk     (clk),
    .rst     (rst),
    .pm1_sts (pm1_sts_q),
    .pm1_en  (pm1_en_q),
    .gpe_sts (gpe_sts_q),
    .gpe_en  (gpe_en_q),
    .sci     (sci)
  );

  always_comb begin
    unique case (sel)
      SEL_PM1_STS: rd_mux = pm1_sts_q;
      SEL_PM1_EN:  rd_mux = pm1_en_q;
      SEL_GPE_STS: rd_mux = DATA_W'(gpe_sts_q);
      SEL_GPE_EN:  rd_mux = DATA_W'(gpe_en_q);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_ack   <= 1'b0;
      io_err   <= 1'b0;
      io_rdata <= '0;
    end else begin
      io_ack   <= io_valid;
      io_err   <= reject;
      io_rdata <= rd_ok ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/pm_event_sci_chk.sv
module pm_event_sci_chk
  import pm_evt_pkg::*;
#(
  parameter int               ADDR_W    = 4,
  parameter int               GPE_W     = 8,
  parameter logic [GPE_W-1:0] GPE_VALID = 'h01,
  parameter int               IDX_W     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              io_valid,
  input logic              io_write,
  input logic [ADDR_W-1:0] io_addr,
  input logic [2:0]        io_bytes,
  input logic [15:0]       io_wdata,
  input logic              io_ack,
  input logic              io_err,
  input logic              pwrbtn_evt,
  input logic              gpe_raise,
  input logic [IDX_W-1:0]  gpe_raise_idx,
  input logic              sci,
  input logic [15:0]       pm1_sts,
  input logic [15:0]       pm1_en,
  input logic [GPE_W-1:0]  gpe_sts,
  input logic [GPE_W-1:0]  gpe_en
);
  logic pm1_addr, gpe_sts_addr, gpe_en_addr;
  assign pm1_addr     = (io_addr == ADDR_W'(OFS_PM1_STS)) || (io_addr == ADDR_W'(OFS_PM1_EN));
  assign gpe_sts_addr = (io_addr == ADDR_W'(OFS_GPE_STS));
  assign gpe_en_addr  = (io_addr == ADDR_W'(OFS_GPE_EN));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!sci && !io_ack && !io_err));

  assert_sts_write_never_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (io_valid && io_write && io_addr == ADDR_W'(OFS_PM1_STS) && !pwrbtn_evt)
    |=> ((pm1_sts & ~$past(pm1_sts)) == 16'h0));

  assert_bad_width_err_R4: assert property (@(posedge clk) disable iff (rst)
    (io_valid && pm1_addr && io_bytes != PM1_BYTES) |=> (io_err && $stable(pm1_en)));

  assert_pwrbtn_sets_R5: assert property (@(posedge clk) disable iff (rst)
    pwrbtn_evt |=> pm1_sts[BIT_PWRBTN]);

  assert_invalid_raise_dropped_R6: assert property (@(posedge clk) disable iff (rst)
    (gpe_raise && !GPE_VALID[gpe_raise_idx] && !(io_valid && gpe_sts_addr))
    |=> $stable(gpe_sts));

  assert_gpe_en_masked_R7: assert property (@(posedge clk) disable iff (rst)
    (io_valid && io_write && gpe_en_addr && io_bytes == GPE_BYTES)
    |=> (gpe_en == ($past(io_wdata[GPE_W-1:0]) & GPE_VALID)));

  assert_sci_rises_R8: assert property (@(posedge clk) disable iff (rst)
    ((|(pm1_sts & pm1_en)) || (|(gpe_sts & gpe_en))) |=> sci);

  assert_sci_falls_R8: assert property (@(posedge clk) disable iff (rst)
    (!(|(pm1_sts & pm1_en)) && !(|(gpe_sts & gpe_en))) |=> !sci);

  assert_ack_follows_R9: assert property (@(posedge clk) disable iff (rst)
    io_valid |=> io_ack);

  assert_no_stray_ack_R9: assert property (@(posedge clk) disable iff (rst)
    !io_valid |=> (!io_ack && !io_err));
endmodule

bind pm_event_sci pm_event_sci_chk #(
  .ADDR_W(ADDR_W), .GPE_W(GPE_W), .GPE_VALID(GPE_VALID), .IDX_W(IDX_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .io_valid      (io_valid),
  .io_write      (io_write),
  .io_addr       (io_addr),
  .io_bytes      (io_bytes),
  .io_wdata      (io_wdata),
  .io_ack        (io_ack),
  .io_err        (io_err),
  .pwrbtn_evt    (pwrbtn_evt),
  .gpe_raise     (gpe_raise),
  .gpe_raise_idx (gpe_raise_idx),
  .sci           (sci),
  .pm1_sts       (pm1_sts_q),
  .pm1_en        (pm1_en_q),
  .gpe_sts       (gpe_sts_q),
  .gpe_en        (gpe_en_q)
);

// File: tb/pm_event_sci_test.sv
module pm_event_sci_test;
  localparam int ADDR_W = 4;
  localparam int GPE_W  = 8;
  localparam logic [GPE_W-1:0] GPE_VALID = 8'h05;
  localparam int IDX_W  = 3;

  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_PB = 2'd2, OP_GR = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [2:0]  bytes;
    logic [15:0] wdata;    // raise index for OP_GR
    logic [15:0] exp_data;
    logic        exp_err;
    logic        exp_sci;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{OP_RD, 4'h0, 3'd2, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R9 read status
    '{OP_WR, 4'h2, 3'd2, 16'hFFFF, 16'h0000, 1'b0, 1'b0}, // R3 enable all
    '{OP_RD, 4'h2, 3'd2, 16'h0000, 16'h0520, 1'b0, 1'b0}, // R3 only 5,8,10 kept
    '{OP_PB, 4'h0, 3'd0, 16'h0000, 16'h0000, 1'b0, 1'b1}, // R5 R8 button -> sci
    '{OP_RD, 4'h0, 3'd2, 16'h0000, 16'h0100, 1'b0, 1'b1}, // R5
    '{OP_WR, 4'h0, 3'd2, 16'h0021, 16'h0000, 1'b0, 1'b1}, // R2 bits 0,5 no effect
    '{OP_RD, 4'h0, 3'd2, 16'h0000, 16'h0100, 1'b0, 1'b1}, // R2
    '{OP_WR, 4'h0, 3'd2, 16'h0100, 16'h0000, 1'b0, 1'b0}, // R2 R8 clear -> sci low
    '{OP_RD, 4'h0, 3'd2, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R2
    '{OP_WR, 4'h2, 3'd2, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R3 disable
    '{OP_PB, 4'h0, 3'd0, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R8 masked event
    '{OP_RD, 4'h0, 3'd2, 16'h0000, 16'h0100, 1'b0, 1'b0}, // R5
    '{OP_WR, 4'h2, 3'd2, 16'h0100, 16'h0000, 1'b0, 1'b1}, // R8 enable after status
    '{OP_WR, 4'h0, 3'd2, 16'h8710, 16'h0000, 1'b0, 1'b0}, // R2 clear all clearable
    '{OP_RD, 4'h0, 3'd2, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R2
    '{OP_WR, 4'h5, 3'd1, 16'h00FF, 16'h0000, 1'b0, 1'b0}, // R7
    '{OP_RD, 4'h5, 3'd1, 16'h0000, 16'h0005, 1'b0, 1'b0}, // R7 masked to valid
    '{OP_GR, 4'h0, 3'd0, 16'h0001, 16'h0000, 1'b0, 1'b0}, // R6 invalid index
    '{OP_RD, 4'h4, 3'd1, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R6
    '{OP_GR, 4'h0, 3'd0, 16'h0002, 16'h0000, 1'b0, 1'b1}, // R6 R8 line 2
    '{OP_RD, 4'h4, 3'd1, 16'h0000, 16'h0004, 1'b0, 1'b1}, // R6
    '{OP_WR, 4'h4, 3'd1, 16'h0001, 16'h0000, 1'b0, 1'b1}, // R6 other bit
    '{OP_WR, 4'h4, 3'd1, 16'h0004, 16'h0000, 1'b0, 1'b0}, // R6 R8 W1C
    '{OP_WR, 4'h0, 3'd1, 16'hFFFF, 16'h0000, 1'b1, 1'b0}, // R4 status width 1
    '{OP_RD, 4'h5, 3'd2, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R4 GPE width 2
    '{OP_RD, 4'h7, 3'd1, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R10 unmapped
    '{OP_WR, 4'h2, 3'd1, 16'hFFFF, 16'h0000, 1'b1, 1'b0}, // R4 enable width 1
    '{OP_RD, 4'h2, 3'd2, 16'h0000, 16'h0100, 1'b0, 1'b0}, // R4 unchanged
    '{OP_WR, 4'h5, 3'd2, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R4
    '{OP_RD, 4'h5, 3'd1, 16'h0000, 16'h0005, 1'b0, 1'b0}, // R4 unchanged
    '{OP_GR, 4'h0, 3'd0, 16'h0000, 16'h0000, 1'b0, 1'b1}, // R8 line 0
    '{OP_WR, 4'h5, 3'd1, 16'h0004, 16'h0000, 1'b0, 1'b0}, // R8 enable removed
    '{OP_RD, 4'h4, 3'd1, 16'h0000, 16'h0001, 1'b0, 1'b0}  // R6 status held
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              io_valid = 1'b0, io_write = 1'b0;
  logic [ADDR_W-1:0] io_addr = '0;
  logic [2:0]        io_bytes = '0;
  logic [15:0]       io_wdata = '0;
  logic              io_ack, io_err;
  logic [15:0]       io_rdata;
  logic              pwrbtn_evt = 1'b0, gpe_raise = 1'b0;
  logic [IDX_W-1:0]  gpe_raise_idx = '0;
  logic              sci;

  int checks = 0, failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pm_event_sci #(.ADDR_W(ADDR_W), .GPE_W(GPE_W), .GPE_VALID(GPE_VALID), .IDX_W(IDX_W)) uut (
    .clk, .rst, .io_valid, .io_write, .io_addr, .io_bytes, .io_wdata,
    .io_ack, .io_err, .io_rdata, .pwrbtn_evt, .gpe_raise, .gpe_raise_idx, .sci
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // drive one step at a negedge, sample response and interrupt level afterwards
  task automatic step(input vec_t v, input int n);
    string tag;
    tag = $sformatf("vec%0d", n);
    @(negedge clk);
    case (v.op)
      OP_RD, OP_WR: begin
        io_valid = 1'b1; io_write = (v.op == OP_WR);
        io_addr = v.addr; io_bytes = v.bytes; io_wdata = v.wdata;
      end
      OP_PB: pwrbtn_evt = 1'b1;
      default: begin gpe_raise = 1'b1; gpe_raise_idx = v.wdata[IDX_W-1:0]; end
    endcase
    @(negedge clk);
    io_valid = 1'b0; pwrbtn_evt = 1'b0; gpe_raise = 1'b0;
    if (v.op == OP_RD || v.op == OP_WR) begin
      chk({tag, " R9 ack"}, 16'(io_ack), 16'h1);
      chk({tag, " R4/R10 err"}, 16'(io_err), 16'(v.exp_err));
      chk({tag, " R9 rdata"}, io_rdata, v.exp_data);
    end
    @(negedge clk);
    chk({tag, " R8 sci"}, 16'(sci), 16'(v.exp_sci));
  endtask

  task automatic rd(input logic [3:0] a, input logic [2:0] b, input logic [15:0] exp, input string req);
    @(negedge clk);
    io_valid = 1'b1; io_write = 1'b0; io_addr = a; io_bytes = b;
    @(negedge clk);
    io_valid = 1'b0;
    chk(req, io_rdata, exp);
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog actual=%0d expected=<20000", cycles);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sci in reset", 16'(sci), 16'h0);
    chk("R1 ack in reset", 16'(io_ack), 16'h0);
    chk("R1 err in reset", 16'(io_err), 16'h0);
    chk("R1 rdata in reset", io_rdata, 16'h0);
    rst = 1'b0;
    rd(4'h0, 3'd2, 16'h0, "R1 status");
    rd(4'h2, 3'd2, 16'h0, "R1 enable");
    rd(4'h4, 3'd1, 16'h0, "R1 gpe status");
    rd(4'h5, 3'd1, 16'h0, "R1 gpe enable");

    for (int i = 0; i < NV; i++) step(VECS[i], i);

    // R5 button event and clearing write in the same cycle: set wins
    @(negedge clk);
    pwrbtn_evt = 1'b1;
    io_valid = 1'b1; io_write = 1'b1; io_addr = 4'h0; io_bytes = 3'd2; io_wdata = 16'h0100;
    @(negedge clk);
    pwrbtn_evt = 1'b0; io_valid = 1'b0;
    rd(4'h0, 3'd2, 16'h0100, "R5 set beats clear");

    // R6 raise and clearing write on line 0 in the same cycle: raise wins
    @(negedge clk);
    gpe_raise = 1'b1; gpe_raise_idx = 3'd0;
    io_valid = 1'b1; io_write = 1'b1; io_addr = 4'h4; io_bytes = 3'd1; io_wdata = 16'h0001;
    @(negedge clk);
    gpe_raise = 1'b0; io_valid = 1'b0;
    rd(4'h4, 3'd1, 16'h0001, "R6 raise beats clear");

    // R1 reset in mid-run while sci is high
    @(negedge clk);
    chk("R8 sci before reset", 16'(sci), 16'h1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 sci after reset", 16'(sci), 16'h0);
    rst = 1'b0;
    rd(4'h2, 3'd2, 16'h0, "R1 enable cleared");
    rd(4'h0, 3'd2, 16'h0, "R1 status cleared");

    finish_run();
  end
endmodule